// File: doc/BRIEF.md
# CCM Counter Block Builder and Tag Checker

This block sits beside a 128-bit AES engine running in CCM mode and handles the framing work around it. On a configuration load it captures the nonce, the size of the length field (L), the tag length (M) and the total ciphertext length. From these it produces three things: the 16-byte initial counter block, the two packed control fields the engine expects, and the payload length. The payload length is also the byte offset of the received tag inside the ciphertext buffer.

After a decryption the host pulses a verify request. The checker waits until the engine reports that its saved context is ready. It then compares the computed tag with the received tag one byte per cycle for exactly M cycles, folding the XOR of each byte pair into an OR accumulator. The run always takes the same number of cycles, wherever the first difference lies. A one-cycle done strobe then reports pass or authentication failure. A tag length the block does not accept produces an error verdict without any comparison. The AES rounds themselves live elsewhere.

Top module: `ccm_tag_unit`

## Requirements
- R1: One cycle after cfgLoad, byte 0 of ctrBlock (bits 7:0) holds L-1, and bytes 1..12 hold nonce bytes 0..11. Byte i of every 8-bit-lane bus sits at bits [8i+7:8i].
- R2: Byte 13 of ctrBlock holds nonce byte 12 when L equals 2 and is zero for any other L. Bytes 14 and 15 are always zero.
- R3: fieldL equals L-1 in 3 bits. fieldM equals (M-2)>>1 in 3 bits when M is at least 2, and 0 when M is 0 or 1.
- R4: payloadLen equals ctLen minus M, which is also the tag offset in the ciphertext. It is 0 when ctLen is below M.
- R5: With a valid M, the verdict is authPass when compTag and rxTag agree in bytes 0..M-1.
- R6: A difference in any single byte among bytes 0..M-1 gives authFail, whether it is the first or the last compared byte.
- R7: Bytes at index M and above in either tag have no effect on the verdict.
- R8: With ctxReady high, done rises at the (M+2)-th rising edge counted from the edge that samples verifyStart, inclusive. The latency does not depend on the tag data or on where a mismatch lies.
- R9: The comparison starts only once ctxReady is high. The tag value present while the block waits is not used, and each cycle of waiting adds one cycle to the latency.
- R10: An M that is odd, below 4 or above 16 makes done rise at the first edge after the request, with tagLenErr=1 and both authPass and authFail at 0.
- R11: After reset, ctrBlock, fieldL, fieldM and payloadLen are all zero, and done, authPass, authFail and tagLenErr are low.
- R12: A verifyStart that arrives while a check is in progress is ignored, so only one done strobe follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLoad | input | 1 | Capture L, M, nonce and ctLen |
| lenL | input | 4 | Length-field size L in bytes |
| tagM | input | 5 | Tag length M in bytes |
| nonce | input | 104 | Nonce, byte i at bits [8i+7:8i] |
| ctLen | input | 16 | Ciphertext length including tag, in bytes |
| verifyStart | input | 1 | Request a tag check |
| ctxReady | input | 1 | Engine saved context (computed tag) is ready |
| compTag | input | 128 | Tag computed by the engine |
| rxTag | input | 128 | Tag received with the message |
| ctrBlock | output | 128 | Initial counter block |
| fieldL | output | 3 | Encoded L control field |
| fieldM | output | 3 | Encoded M control field |
| payloadLen | output | 16 | Payload length and tag offset |
| done | output | 1 | One-cycle verdict strobe |
| authPass | output | 1 | Last verdict: tags agree |
| authFail | output | 1 | Last verdict: tags differ |
| tagLenErr | output | 1 | Last verdict: M rejected |

## Verification
The counter block is loaded with L equal to 2 and with L equal to 3, using a nonce whose bytes are all distinct. This separates the conditional byte 13 from the fixed bytes and catches any shift in the byte placement. Tag pairs are compared in four forms: identical; differing only in byte 0; differing only in byte M-1; and differing only beyond M. Together these tell apart the accumulator, the compare window and the fixed latency. Runs with a late context-ready signal and a changing tag, runs with odd, small and oversized M, and a repeated request during a busy check cover the gating and rejection paths.

// File: rtl/ccm_tag_pkg.sv
package ccm_tag_pkg;
  // strobes from the sequencer to the comparison datapath
  typedef struct packed {
    logic clrAcc;
    logic accEn;
    logic finish;
    logic reject;
  } tagStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } tagState_t;
endpackage

// File: rtl/ccm_ctr_format.sv
module ccm_ctr_format #(
  parameter int NONCE_BYTES = 13,
  parameter int BLK_BYTES   = 16,
  parameter int LEN_W       = 16,
  parameter int LW          = 4,
  parameter int MW          = 5,
  parameter int MIN_TAG     = 4,
  parameter int MAX_TAG     = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLoad,
  input  logic [LW-1:0]            lenL,
  input  logic [MW-1:0]            tagM,
  input  logic [8*NONCE_BYTES-1:0] nonce,
  input  logic [LEN_W-1:0]         ctLen,
  output logic [8*BLK_BYTES-1:0]   ctrBlock,
  output logic [2:0]               fieldL,
  output logic [2:0]               fieldM,
  output logic [LEN_W-1:0]         payloadLen,
  output logic [MW-1:0]            mLat,
  output logic                     mOk
);
  localparam int FIXED_NONCE = 12;
  localparam int COND_BYTE   = FIXED_NONCE + 1;

  logic [LW-1:0]            lReg;
  logic [MW-1:0]            mReg;
  logic [8*NONCE_BYTES-1:0] nonceReg;
  logic [LEN_W-1:0]         ctLenReg;

  // reset leaves L=1 so that every derived field reads as zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lReg     <= LW'(1);
      mReg     <= '0;
      nonceReg <= '0;
      ctLenReg <= '0;
    end else if (cfgLoad) begin
      lReg     <= lenL;
      mReg     <= tagM;
      nonceReg <= nonce;
      ctLenReg <= ctLen;
    end
  end

  logic [LW-1:0]    lMinus1;
  logic [MW-1:0]    mMinus2;
  logic [LEN_W-1:0] mWide;

  assign lMinus1 = lReg - LW'(1);
  assign mMinus2 = mReg - MW'(2);
  assign mWide   = LEN_W'(mReg);

  assign fieldL     = lMinus1[2:0];
  assign fieldM     = (mReg >= MW'(2)) ? mMinus2[3:1] : 3'd0;
  assign payloadLen = (ctLenReg >= mWide) ? (ctLenReg - mWide) : '0;
  assign mLat       = mReg;
  assign mOk        = (mReg >= MW'(MIN_TAG)) && (mReg <= MW'(MAX_TAG)) && !mReg[0];

  // byte lanes of the counter block
  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_lane
    if (b == 0) begin : g_flags
      assign ctrBlock[8*b +: 8] = 8'(lMinus1);
    end else if (b <= FIXED_NONCE) begin : g_nonce
      assign ctrBlock[8*b +: 8] = nonceReg[8*(b-1) +: 8];
    end else if (b == COND_BYTE) begin : g_cond
      assign ctrBlock[8*b +: 8] = (lReg == LW'(2)) ? nonceReg[8*FIXED_NONCE +: 8] : 8'd0;
    end else begin : g_zero
      assign ctrBlock[8*b +: 8] = 8'd0;
    end
  end
endmodule

// File: rtl/ccm_tag_ctrl.sv
module ccm_tag_ctrl
  import ccm_tag_pkg::*;
#(
  parameter int MW    = 5,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             verifyStart,
  input  logic             ctxReady,
  input  logic [MW-1:0]    mLat,
  input  logic             mOk,
  output tagStrobe_t       strobe,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  tagState_t        state, stNext;
  logic [IDX_W-1:0] idxNext;
  logic [MW-1:0]    mLast;
  logic             lastHit;

  assign mLast   = mLat - MW'(1);
  assign lastHit = (MW'(idx) == mLast);

  always_comb begin
    strobe  = '0;
    stNext  = state;
    idxNext = idx;
    case (state)
      ST_IDLE: begin
        if (verifyStart) begin
          if (mOk) stNext = ST_WAIT;
          else     strobe.reject = 1'b1;
        end
      end
      ST_WAIT: begin
        if (ctxReady) begin
          strobe.clrAcc = 1'b1;
          idxNext       = '0;
          stNext        = ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.accEn = 1'b1;
        if (lastHit) begin
          strobe.finish = 1'b1;
          stNext        = ST_IDLE;
        end else begin
          idxNext = idx + IDX_W'(1);
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stNext;
      idx   <= idxNext;
      done  <= strobe.finish | strobe.reject;
    end
  end
endmodule

// File: rtl/ccm_tag_dp.sv
module ccm_tag_dp
  import ccm_tag_pkg::*;
#(
  parameter int TAG_BYTES = 16,
  parameter int IDX_W     = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tagStrobe_t             strobe,
  input  logic [IDX_W-1:0]       idx,
  input  logic [8*TAG_BYTES-1:0] compTag,
  input  logic [8*TAG_BYTES-1:0] rxTag,
  output logic                   authPass,
  output logic                   authFail,
  output logic                   tagLenErr
);
  logic [7:0] acc, accNext, compByte, rxByte;

  assign compByte = compTag[8*idx +: 8];
  assign rxByte   = rxTag[8*idx +: 8];
  assign accNext  = acc | (compByte ^ rxByte);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      authPass  <= 1'b0;
      authFail  <= 1'b0;
      tagLenErr <= 1'b0;
    end else begin
      if (strobe.clrAcc)     acc <= '0;
      else if (strobe.accEn) acc <= accNext;

      if (strobe.finish) begin
        authPass  <= (accNext == 8'd0);
        authFail  <= (accNext != 8'd0);
        tagLenErr <= 1'b0;
      end else if (strobe.reject) begin
        authPass  <= 1'b0;
        authFail  <= 1'b0;
        tagLenErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ccm_tag_unit.sv
module ccm_tag_unit
  import ccm_tag_pkg::*;
#(
  parameter int NONCE_BYTES = 13,
  parameter int BLK_BYTES   = 16,
  parameter int LEN_W       = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLoad,
  input  logic [3:0]               lenL,
  input  logic [4:0]               tagM,
  input  logic [8*NONCE_BYTES-1:0] nonce,
  input  logic [LEN_W-1:0]         ctLen,
  input  logic                     verifyStart,
  input  logic                     ctxReady,
  input  logic [8*BLK_BYTES-1:0]   compTag,
  input  logic [8*BLK_BYTES-1:0]   rxTag,
  output logic [8*BLK_BYTES-1:0]   ctrBlock,
  output logic [2:0]               fieldL,
  output logic [2:0]               fieldM,
  output logic [LEN_W-1:0]         payloadLen,
  output logic                     done,
  output logic                     authPass,
  output logic                     authFail,
  output logic                     tagLenErr
);
  localparam int MW    = 5;
  localparam int IDX_W = $clog2(BLK_BYTES);

  logic [MW-1:0]    mLat;
  logic             mOk;
  tagStrobe_t       strobe;
  logic [IDX_W-1:0] idx;

  ccm_ctr_format #(
    .NONCE_BYTES(NONCE_BYTES), .BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W),
    .LW(4), .MW(MW), .MIN_TAG(4), .MAX_TAG(BLK_BYTES)
  ) u_fmt (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .lenL(lenL), .tagM(tagM),
    .nonce(nonce), .ctLen(ctLen), .ctrBlock(ctrBlock), .fieldL(fieldL),
    .fieldM(fieldM), .payloadLen(payloadLen), .mLat(mLat), .mOk(mOk)
  );

  ccm_tag_ctrl #(.MW(MW), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .verifyStart(verifyStart), .ctxReady(ctxReady),
    .mLat(mLat), .mOk(mOk), .strobe(strobe), .idx(idx), .done(done)
  );

  ccm_tag_dp #(.TAG_BYTES(BLK_BYTES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx),
    .compTag(compTag), .rxTag(rxTag),
    .authPass(authPass), .authFail(authFail), .tagLenErr(tagLenErr)
  );
endmodule

// File: rtl/ccm_tag_unit_chk.sv
module ccm_tag_unit_chk #(
  parameter int NONCE_BYTES = 13,
  parameter int BLK_BYTES   = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cfgLoad,
  input logic [3:0]               lenL,
  input logic [8*NONCE_BYTES-1:0] nonce,
  input logic [8*BLK_BYTES-1:0]   ctrBlock,
  input logic [2:0]               fieldL,
  input logic                     done,
  input logic                     authPass,
  input logic                     authFail,
  input logic                     tagLenErr
);
  // R1
  ctr_head_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgLoad) |-> (ctrBlock[7:0] == 8'($past(lenL)) - 8'd1)
                       && (ctrBlock[15:8] == $past(nonce[7:0])));

  // R2
  ctr_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgLoad) |-> (ctrBlock[8*BLK_BYTES-1 -: 16] == 16'd0)
      && (ctrBlock[111:104] == (($past(lenL) == 4'd2) ? $past(nonce[103:96]) : 8'd0)));

  // R3
  field_l_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgLoad) |-> fieldL == 3'($past(lenL) - 4'd1));

  // R10
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({authPass, authFail, tagLenErr}));

  // R8
  no_quick_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !tagLenErr) |-> !$past(done));
endmodule

bind ccm_tag_unit ccm_tag_unit_chk #(.NONCE_BYTES(NONCE_BYTES), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .lenL(lenL), .nonce(nonce),
  .ctrBlock(ctrBlock), .fieldL(fieldL), .done(done), .authPass(authPass),
  .authFail(authFail), .tagLenErr(tagLenErr)
);

// File: tb/tb_ccm_tag_unit.sv
module tb_ccm_tag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic         clk = 1'b0;
  logic         rstN;
  logic         cfgLoad, verifyStart, ctxReady;
  logic [3:0]   lenL;
  logic [4:0]   tagM;
  logic [103:0] nonce;
  logic [15:0]  ctLen;
  logic [127:0] compTag, rxTag;
  logic [127:0] ctrBlock;
  logic [2:0]   fieldL, fieldM;
  logic [15:0]  payloadLen;
  logic         done, authPass, authFail, tagLenErr;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccm_tag_unit dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .lenL(lenL), .tagM(tagM),
    .nonce(nonce), .ctLen(ctLen), .verifyStart(verifyStart), .ctxReady(ctxReady),
    .compTag(compTag), .rxTag(rxTag), .ctrBlock(ctrBlock), .fieldL(fieldL),
    .fieldM(fieldM), .payloadLen(payloadLen), .done(done), .authPass(authPass),
    .authFail(authFail), .tagLenErr(tagLenErr)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expCtr(input logic [3:0] l, input logic [103:0] n);
    logic [127:0] v = '0;
    v[7:0] = 8'(l) - 8'd1;
    for (int i = 1; i <= 12; i++) v[8*i +: 8] = n[8*(i-1) +: 8];
    if (l == 4'd2) v[111:104] = n[103:96];
    return v;
  endfunction

  task automatic loadCfg(input logic [3:0] l, input logic [4:0] m, input logic [15:0] len);
    lenL = l; tagM = m; ctLen = len; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // returns the number of edges from the sampling edge of the request to done
  task automatic runVerify(output int cnt);
    ctxReady = 1'b1; verifyStart = 1'b1;
    @(negedge clk);
    verifyStart = 1'b0;
    cnt = 1;
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  function automatic logic [127:0] tagPattern(input logic [7:0] seed);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = seed + 8'(i * 29);
    return v;
  endfunction

  task automatic t_reset();
    check("R11 ctrBlock", ctrBlock, 128'd0);
    check("R11 fieldL", 128'(fieldL), 128'd0);
    check("R11 fieldM", 128'(fieldM), 128'd0);
    check("R11 payloadLen", 128'(payloadLen), 128'd0);
    check("R11 flags", 128'({done, authPass, authFail, tagLenErr}), 128'd0);
  endtask

  task automatic t_ctr_l2();
    for (int i = 0; i < 13; i++) nonce[8*i +: 8] = 8'hA0 + 8'(i);
    loadCfg(4'd2, 5'd8, 16'd40);
    check("R1 R2 ctr L=2", ctrBlock, expCtr(4'd2, nonce));
    check("R3 fieldL L=2", 128'(fieldL), 128'd1);
    check("R3 fieldM M=8", 128'(fieldM), 128'd3);
    check("R4 payloadLen", 128'(payloadLen), 128'd32);
  endtask

  task automatic t_ctr_l3();
    for (int i = 0; i < 13; i++) nonce[8*i +: 8] = 8'h31 + 8'(i * 7);
    loadCfg(4'd3, 5'd8, 16'd5);
    check("R2 ctr L=3 byte13 zero", ctrBlock, expCtr(4'd3, nonce));
    check("R3 fieldL L=3", 128'(fieldL), 128'd2);
    check("R4 payloadLen saturates", 128'(payloadLen), 128'd0);
  endtask

  task automatic t_field_m();
    loadCfg(4'd2, 5'd16, 16'd100);
    check("R3 fieldM M=16", 128'(fieldM), 128'd7);
    check("R4 payloadLen M=16", 128'(payloadLen), 128'd84);
    loadCfg(4'd2, 5'd1, 16'd100);
    check("R3 fieldM M=1", 128'(fieldM), 128'd0);
    loadCfg(4'd2, 5'd0, 16'd100);
    check("R3 fieldM M=0", 128'(fieldM), 128'd0);
  endtask

  task automatic t_match();
    int cnt;
    loadCfg(4'd2, 5'd16, 16'd64);
    compTag = tagPattern(8'h5C); rxTag = tagPattern(8'h5C);
    runVerify(cnt);
    check("R5 pass M=16", 128'({authPass, authFail, tagLenErr}), 128'b100);
    check("R8 latency M=16", 128'(cnt), 128'd18);
    @(negedge clk);
  endtask

  task automatic t_mismatch(input int pos);
    int cnt;
    loadCfg(4'd2, 5'd8, 16'd64);
    compTag = tagPattern(8'h11); rxTag = tagPattern(8'h11);
    rxTag[8*pos +: 8] = rxTag[8*pos +: 8] ^ 8'h40;
    runVerify(cnt);
    check("R6 fail on single byte", 128'({authPass, authFail, tagLenErr}), 128'b010);
    check("R8 latency with mismatch", 128'(cnt), 128'd10);
    @(negedge clk);
  endtask

  task automatic t_ignore_tail();
    int cnt;
    loadCfg(4'd2, 5'd4, 16'd64);
    compTag = tagPattern(8'h77); rxTag = compTag;
    rxTag[127:32] = ~compTag[127:32];
    runVerify(cnt);
    check("R7 bytes beyond M ignored", 128'({authPass, authFail, tagLenErr}), 128'b100);
    check("R8 latency M=4", 128'(cnt), 128'd6);
    @(negedge clk);
  endtask

  task automatic t_ctx_wait();
    int cnt;
    loadCfg(4'd2, 5'd6, 16'd64);
    rxTag = tagPattern(8'h09); compTag = ~rxTag;
    ctxReady = 1'b0; verifyStart = 1'b1;
    @(negedge clk);
    verifyStart = 1'b0;
    cnt = 1;
    repeat (3) begin @(negedge clk); cnt++; end
    check("R9 no verdict while waiting", 128'(done), 128'd0);
    compTag = rxTag; ctxReady = 1'b1;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    check("R9 tag taken after ready", 128'({authPass, authFail, tagLenErr}), 128'b100);
    check("R9 latency grows with wait", 128'(cnt), 128'd11);
    @(negedge clk);
  endtask

  task automatic t_bad_m(input logic [4:0] m);
    int cnt;
    loadCfg(4'd2, m, 16'd64);
    compTag = tagPattern(8'h01); rxTag = compTag;
    runVerify(cnt);
    check("R10 rejected M verdict", 128'({authPass, authFail, tagLenErr}), 128'b001);
    check("R10 rejected M latency", 128'(cnt), 128'd1);
    @(negedge clk);
  endtask

  task automatic t_busy();
    int cnt;
    int extra;
    loadCfg(4'd2, 5'd4, 16'd64);
    compTag = tagPattern(8'h22); rxTag = compTag;
    ctxReady = 1'b1; verifyStart = 1'b1;
    @(negedge clk);
    verifyStart = 1'b0;
    cnt = 1;
    @(negedge clk); cnt++;
    verifyStart = 1'b1;
    @(negedge clk); cnt++;
    verifyStart = 1'b0;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    check("R12 first check completes", 128'(cnt), 128'd6);
    extra = 0;
    repeat (8) begin @(negedge clk); if (done) extra++; end
    check("R12 second request ignored", 128'(extra), 128'd0);
  endtask

  initial begin
    rstN = 1'b0; cfgLoad = 1'b0; verifyStart = 1'b0; ctxReady = 1'b0;
    lenL = '0; tagM = '0; nonce = '0; ctLen = '0; compTag = '0; rxTag = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctr_l2();
    t_ctr_l3();
    t_field_m();
    t_match();
    t_mismatch(0);
    t_mismatch(7);
    t_ignore_tail();
    t_ctx_wait();
    t_bad_m(5'd5);
    t_bad_m(5'd2);
    t_bad_m(5'd18);
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule